// File: doc/BRIEF.md
# Linked Descriptor Chain Sequencer

This block walks a linked list of transfer descriptors kept in memory and turns each one into a single copy request for an external data mover. Software loads the address of the first descriptor, sets the start bit, and the sequencer then fetches descriptors one 32-bit word at a time through a synchronous read port. For each descriptor it hands the source address, destination address and byte count to the mover over a request/done handshake. It then follows the link word to the next descriptor until it reaches one whose link marks the end of the list.

Each descriptor is 32-byte aligned. The five low bits of its link word are therefore free, and two of them carry per-descriptor control: an end-of-list marker and an end-of-segment event request. A descriptor with a zero byte count issues no copy and is flagged as a programming error. Completion events collect in a status register that software clears by writing ones. The interrupt line is the OR of every pending event that has its enable bit set. A running chain can be aborted, which leaves the channel idle and marked halted.

Top module: `desc_chain_seq`

## Requirements
- R1: After reset the status register reads zero, the current-descriptor register reads zero, and `irq`, `xfer_req` and `rd_en` are low.
- R2: Launching reads seven words at byte offsets 0 to 24 of the current descriptor, in increasing order. The words are, in order: source low, source high, destination low, destination high, link low, link high, byte count. Each descriptor then issues exactly one copy request, with source and destination truncated to AW bits and length equal to the count word. The request stays up with stable fields until `xfer_done`. A launch is a 0-to-1 change of mode bit 0 (start) while the channel is idle. The register offsets are 0 mode, 1 status, 2 current-descriptor low, 3 current-descriptor high.
- R3: Link bit 0 (end of list) makes the chain stop after that descriptor completes. Busy then clears and status bit 9 (end-of-links event) is set.
- R4: Link bit 1 sets status bit 8 (end-of-segment event) when that descriptor completes.
- R5: When a descriptor completes without end of list, the current-descriptor register takes the link address with its low five bits cleared, and the next fetch uses that address.
- R6: A zero byte count sets status bit 10 (programming error) and issues no copy request. The descriptor's link flags are still handled, so the chain continues or stops as the flags say.
- R7: Status bit 0 is busy and bit 1 is halted, both live. Writing ones to bits 8 to 10 clears those events. Writing to bits 0 and 1 has no effect, and other event bits stay as they were.
- R8: A 0-to-1 change of mode bit 1 (abort) while busy withdraws any request, clears busy and sets halted, so the channel reports idle. The next launch clears halted.
- R9: `irq` is high exactly when some status event bit 8 to 10 is set while the enable bit at the same position of the mode register is set.
- R10: The current-descriptor register accepts writes only while idle; writes during a chain are ignored. The high register holds AW-32 bits, and higher written bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| rd_en | output | 1 | Descriptor word read strobe |
| rd_addr | output | AW | Descriptor word byte address |
| rd_data | input | 32 | Read data, valid the cycle after rd_en |
| xfer_req | output | 1 | Copy request to the data mover |
| xfer_src | output | AW | Copy source address |
| xfer_dst | output | AW | Copy destination address |
| xfer_len | output | CW | Copy byte count |
| xfer_done | input | 1 | Copy finished, one-cycle pulse |

## Verification
The bench builds the sequencer with AW = 40 and CW = 32. A 40-bit address makes the high half of the current-descriptor register only eight bits wide, so dropped upper write bits show up on readback. It also means descriptor addresses whose upper 24 bits are nonzero must arrive truncated at the copy port. Keeping CW at the full word width lets every count value, including zero, reach the programming-error path.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int DESC_WORDS  = 7;
    localparam int IDX_W       = 3;
    localparam int LINK_ALIGN  = 5;

    localparam logic [1:0] RA_MODE = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_CDLO = 2'd2;
    localparam logic [1:0] RA_CDHI = 2'd3;

    localparam int MB_START = 0;
    localparam int MB_ABORT = 1;
    localparam int SB_BUSY  = 0;
    localparam int SB_HALT  = 1;
    localparam int EV_BASE  = 8;
    localparam int EV_N     = 3;
    localparam int EV_EOS   = 0;
    localparam int EV_EOL   = 1;
    localparam int EV_PERR  = 2;

    localparam int LF_EOL = 0;
    localparam int LF_EOS = 1;

    typedef enum logic [2:0] {
        W_IDLE, W_FETCH, W_LAST, W_XFER, W_DONE
    } walk_st_t;

    typedef struct packed {
        logic [EV_N-1:0] ie;
        logic            abort;
        logic            start;
    } mode_t;

    function automatic logic [31:0] clear_align(input logic [31:0] w);
        return {w[31:LINK_ALIGN], {LINK_ALIGN{1'b0}}};
    endfunction

endpackage

// File: rtl/dcs_walker.sv
module dcs_walker
    import dcs_pkg::*;
#(
    parameter int AW = 64,
    parameter int CW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_p,
    input  logic            abort_p,
    input  logic            cda_wr_lo,
    input  logic            cda_wr_hi,
    input  logic [31:0]     wdata,
    output logic [AW-1:0]   cda_q,
    output logic            busy,
    output logic            halted,
    output logic [EV_N-1:0] ev_pulse,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    input  logic [31:0]     rd_data,
    output logic            xfer_req,
    output logic [AW-1:0]   xfer_src,
    output logic [AW-1:0]   xfer_dst,
    output logic [CW-1:0]   xfer_len,
    input  logic            xfer_done
);
    localparam int HIW = AW - 32;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    walk_st_t         st;
    logic [IDX_W-1:0] idx, cap_idx;
    logic             cap_v;
    logic [AW-1:0]    src_q, dst_q, link_q;
    logic [1:0]       flags_q;
    logic [CW-1:0]    len_q;

    assign busy     = (st != W_IDLE);
    assign rd_en    = (st == W_FETCH);
    assign rd_addr  = {cda_q[AW-1:LINK_ALIGN], idx, 2'b00};
    assign xfer_req = (st == W_XFER);
    assign xfer_src = src_q;
    assign xfer_dst = dst_q;
    assign xfer_len = len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= W_IDLE;
            cda_q    <= '0;
            idx      <= '0;
            cap_idx  <= '0;
            cap_v    <= 1'b0;
            src_q    <= '0;
            dst_q    <= '0;
            link_q   <= '0;
            flags_q  <= '0;
            len_q    <= '0;
            halted   <= 1'b0;
            ev_pulse <= '0;
        end else begin
            ev_pulse <= '0;
            cap_v    <= (st == W_FETCH);
            cap_idx  <= idx;
            if (cap_v) begin
                case (cap_idx)
                    3'd0: src_q[31:0]   <= rd_data;
                    3'd1: src_q[AW-1:32] <= rd_data[HIW-1:0];
                    3'd2: dst_q[31:0]   <= rd_data;
                    3'd3: dst_q[AW-1:32] <= rd_data[HIW-1:0];
                    3'd4: begin
                        link_q[31:0] <= clear_align(rd_data);
                        flags_q      <= rd_data[1:0];
                    end
                    3'd5: link_q[AW-1:32] <= rd_data[HIW-1:0];
                    default: ;
                endcase
            end
            if (st == W_IDLE && cda_wr_lo) cda_q[31:0]    <= wdata;
            if (st == W_IDLE && cda_wr_hi) cda_q[AW-1:32] <= wdata[HIW-1:0];
            case (st)
                W_IDLE: if (start_p) begin
                    st     <= W_FETCH;
                    idx    <= '0;
                    halted <= 1'b0;
                end
                W_FETCH: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST_IDX) st <= W_LAST;
                end
                W_LAST: begin
                    // count word is on the read port in this cycle
                    if (rd_data[CW-1:0] == '0) begin
                        ev_pulse[EV_PERR] <= 1'b1;
                        st <= W_DONE;
                    end else begin
                        len_q <= rd_data[CW-1:0];
                        st    <= W_XFER;
                    end
                end
                W_XFER: if (xfer_done) st <= W_DONE;
                W_DONE: begin
                    ev_pulse[EV_EOS] <= flags_q[LF_EOS];
                    if (flags_q[LF_EOL]) begin
                        ev_pulse[EV_EOL] <= 1'b1;
                        st <= W_IDLE;
                    end else begin
                        cda_q <= link_q;
                        idx   <= '0;
                        st    <= W_FETCH;
                    end
                end
                default: st <= W_IDLE;
            endcase
            if (abort_p && st != W_IDLE) begin
                st     <= W_IDLE;
                halted <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dcs_regs.sv
module dcs_regs
    import dcs_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            start_p,
    output logic            abort_p,
    output logic            cda_wr_lo,
    output logic            cda_wr_hi,
    input  logic [AW-1:0]   cda_q,
    input  logic            busy,
    input  logic            halted,
    input  logic [EV_N-1:0] ev_pulse,
    output logic            irq
);
    mode_t           mode_q;
    logic [EV_N-1:0] ev_q, ev_clr;
    logic            wr_mode;

    assign wr_mode   = reg_we && (reg_addr == RA_MODE);
    assign start_p   = wr_mode && reg_wdata[MB_START] && !mode_q.start;
    assign abort_p   = wr_mode && reg_wdata[MB_ABORT] && !mode_q.abort;
    assign cda_wr_lo = reg_we && (reg_addr == RA_CDLO);
    assign cda_wr_hi = reg_we && (reg_addr == RA_CDHI);
    assign ev_clr    = (reg_we && reg_addr == RA_STAT) ? reg_wdata[EV_BASE +: EV_N] : '0;
    assign irq       = |(ev_q & mode_q.ie);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ev_q   <= '0;
        end else begin
            if (wr_mode) begin
                mode_q.start <= reg_wdata[MB_START];
                mode_q.abort <= reg_wdata[MB_ABORT];
                mode_q.ie    <= reg_wdata[EV_BASE +: EV_N];
            end
            ev_q <= (ev_q & ~ev_clr) | ev_pulse;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MODE: begin
                reg_rdata[MB_START]          = mode_q.start;
                reg_rdata[MB_ABORT]          = mode_q.abort;
                reg_rdata[EV_BASE +: EV_N]   = mode_q.ie;
            end
            RA_STAT: begin
                reg_rdata[SB_BUSY]           = busy;
                reg_rdata[SB_HALT]           = halted;
                reg_rdata[EV_BASE +: EV_N]   = ev_q;
            end
            RA_CDLO: reg_rdata = cda_q[31:0];
            default: reg_rdata = {{(64-AW){1'b0}}, cda_q[AW-1:32]};
        endcase
    end
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
    import dcs_pkg::*;
#(
    parameter int AW = 64,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [31:0]   rd_data,
    output logic          xfer_req,
    output logic [AW-1:0] xfer_src,
    output logic [AW-1:0] xfer_dst,
    output logic [CW-1:0] xfer_len,
    input  logic          xfer_done
);
    logic            start_p_w, abort_p_w, cda_wr_lo_w, cda_wr_hi_w;
    logic            busy_w, halted_w;
    logic [AW-1:0]   cda_w;
    logic [EV_N-1:0] ev_w;

    dcs_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .start_p(start_p_w), .abort_p(abort_p_w),
        .cda_wr_lo(cda_wr_lo_w), .cda_wr_hi(cda_wr_hi_w), .cda_q(cda_w),
        .busy(busy_w), .halted(halted_w), .ev_pulse(ev_w), .irq(irq)
    );

    dcs_walker #(.AW(AW), .CW(CW)) u_walk (
        .clk(clk), .rst(rst),
        .start_p(start_p_w), .abort_p(abort_p_w),
        .cda_wr_lo(cda_wr_lo_w), .cda_wr_hi(cda_wr_hi_w), .wdata(reg_wdata),
        .cda_q(cda_w), .busy(busy_w), .halted(halted_w), .ev_pulse(ev_w),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_done(xfer_done)
    );
endmodule

// File: rtl/dcs_check.sv
module dcs_check #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic [4:0]    addr_lo,
    input logic          xfer_req,
    input logic [AW-1:0] xfer_src,
    input logic          xfer_done,
    input logic          busy,
    input logic          halted,
    input logic          abort_p
);
    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (addr_lo[1:0] == 2'b00 && addr_lo[4:2] != 3'd7)); // R5

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> busy); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_done && !abort_p) |=> (xfer_req && $stable(xfer_src))); // R2

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (abort_p && busy) |=> (!busy && halted && !xfer_req)); // R8

    AST_HALT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        halted |-> !busy); // R8
endmodule

bind desc_chain_seq dcs_check #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr_lo(rd_addr[4:0]),
    .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_done(xfer_done),
    .busy(busy_w), .halted(halted_w), .abort_p(abort_p_w)
);

// File: tb/sim_desc_chain_seq.sv
`timescale 1ns/1ps
module sim_desc_chain_seq;
    localparam int AW = 40;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq, rd_en, xfer_req;
    logic [AW-1:0] rd_addr, xfer_src, xfer_dst;
    logic [31:0]   rd_data = '0;
    logic [CW-1:0] xfer_len;
    logic          xfer_done = 1'b0;

    always #4 clk = ~clk;

    desc_chain_seq #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_done(xfer_done)
    );

    logic [31:0] mem [0:127];
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[8:2]];

    typedef struct { logic [AW-1:0] s; logic [AW-1:0] d; logic [31:0] n; } item_t;
    item_t q[$];
    int total = 0, bad = 0;
    bit hold_done = 0, finished = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic put_desc(int base, logic [63:0] s, logic [63:0] d, logic [63:0] l, logic [31:0] n);
        mem[base/4+0] = s[31:0]; mem[base/4+1] = s[63:32];
        mem[base/4+2] = d[31:0]; mem[base/4+3] = d[63:32];
        mem[base/4+4] = l[31:0]; mem[base/4+5] = l[63:32];
        mem[base/4+6] = n;
    endtask

    task automatic expect_copy(logic [63:0] s, logic [63:0] d, logic [31:0] n);
        item_t it;
        it.s = s[AW-1:0]; it.d = d[AW-1:0]; it.n = n;
        q.push_back(it);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(2'd1, v);
            if (!v[0]) break;
        end
    endtask

    // monitor: acts as data mover and compares against the scoreboard
    initial begin
        forever begin
            @(posedge xfer_req);
            #1;
            if (q.size() == 0) begin
                total++; bad++;
                $display("FAIL R2/R6 unexpected request act=%h exp=none", xfer_src);
            end else begin
                item_t e;
                e = q.pop_front();
                chk("R2 src", 64'(xfer_src), 64'(e.s));
                chk("R2 dst", 64'(xfer_dst), 64'(e.d));
                chk("R2 len", 64'(xfer_len), 64'(e.n));
            end
            if (!hold_done) begin
                repeat (2) @(negedge clk);
                xfer_done = 1'b1;
                @(negedge clk);
                xfer_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R2 act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(2'd1, v); chk("R1 status", 64'(v), 64'h0);
        rd(2'd2, v); chk("R1 cda", 64'(v), 64'h0);
        chk("R1 irq", 64'(irq), 64'h0);
        chk("R1 req", 64'(xfer_req), 64'h0);
        chk("R1 rd_en", 64'(rd_en), 64'h0);

        // R10 high register width
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R10 cda hi width", 64'(v), 64'hFF);
        wr(2'd3, 32'h0);

        // three-descriptor chain, R2 R3 R4 R5
        put_desc(32'h20, 64'hABCD_00EF_1000_0000, 64'h0000_0022_2000_0100, 64'h42, 32'd16);
        put_desc(32'h40, 64'h100, 64'h200, 64'h7C, 32'd8);
        put_desc(32'h60, 64'h300, 64'h400, 64'h1, 32'd4);
        expect_copy(64'hABCD_00EF_1000_0000, 64'h0000_0022_2000_0100, 32'd16);
        expect_copy(64'h100, 64'h200, 32'd8);
        expect_copy(64'h300, 64'h400, 32'd4);
        wr(2'd2, 32'h20);
        wr(2'd0, 32'h701);
        wait_idle();
        chk("R2 all copies issued", 64'(q.size()), 64'h0);
        rd(2'd1, v); chk("R3 R4 status eol+eos", 64'(v), 64'h300);
        chk("R9 irq on", 64'(irq), 64'h1);
        rd(2'd2, v); chk("R5 cda masked link", 64'(v), 64'h60);

        // R7 write-one-to-clear
        wr(2'd1, 32'h103);
        rd(2'd1, v); chk("R7 clear eos only", 64'(v), 64'h200);
        chk("R9 irq still on", 64'(irq), 64'h1);
        wr(2'd1, 32'h200);
        rd(2'd1, v); chk("R7 all clear", 64'(v), 64'h0);
        chk("R9 irq off", 64'(irq), 64'h0);

        // R9 masked event
        wr(2'd0, 32'h100);
        put_desc(32'h80, 64'h500, 64'h600, 64'h1, 32'd2);
        expect_copy(64'h500, 64'h600, 32'd2);
        wr(2'd2, 32'h80);
        wr(2'd0, 32'h101);
        wait_idle();
        rd(2'd1, v); chk("R3 eol set masked", 64'(v), 64'h200);
        chk("R9 irq masked", 64'(irq), 64'h0);
        wr(2'd1, 32'h700);

        // R6 zero count mid-chain
        wr(2'd0, 32'h700);
        put_desc(32'hA0, 64'h900, 64'hA00, 64'hC0, 32'd0);
        put_desc(32'hC0, 64'hB00, 64'hC00, 64'h1, 32'd6);
        expect_copy(64'hB00, 64'hC00, 32'd6);
        wr(2'd2, 32'hA0);
        wr(2'd0, 32'h701);
        wait_idle();
        rd(2'd1, v); chk("R6 perr+eol", 64'(v), 64'h600);
        chk("R6 only one copy", 64'(q.size()), 64'h0);
        wr(2'd1, 32'h700);

        // R8 abort, R10 write ignored while busy
        wr(2'd0, 32'h700);
        put_desc(32'hE0, 64'h700, 64'h800, 64'h1, 32'd32);
        hold_done = 1;
        expect_copy(64'h700, 64'h800, 32'd32);
        wr(2'd2, 32'hE0);
        wr(2'd0, 32'h701);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (xfer_req) break;
        end
        chk("R2 request raised", 64'(xfer_req), 64'h1);
        wr(2'd2, 32'h1E0);
        wr(2'd0, 32'h703);
        rd(2'd1, v); chk("R8 halted idle", 64'(v), 64'h002);
        chk("R8 request withdrawn", 64'(xfer_req), 64'h0);
        rd(2'd2, v); chk("R10 write while busy ignored", 64'(v), 64'hE0);
        wr(2'd0, 32'h700);
        hold_done = 0;
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R8 stays halted", 64'(v), 64'h002);

        // R8 relaunch clears halted
        expect_copy(64'h700, 64'h800, 32'd32);
        wr(2'd0, 32'h701);
        wait_idle();
        rd(2'd1, v); chk("R8 relaunch status", 64'(v), 64'h200);
        chk("R2 relaunch copy", 64'(q.size()), 64'h0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule